// File: doc/BRIEF.md
# Stereo PCM Peak Meter with Serial Frame Readout

The block watches a stream of stereo 16-bit PCM samples and keeps one shared peak: the largest magnitude seen on the left or the right channel. When the peak grows, the block records the event. The absolute time carried by the next subcode frame whose CRC check is good is then captured and held next to the peak. The relative time follows every good subcode frame as usual.

An external reader fetches the result as a 96-bit serial frame. The reader drives a read clock that idles high and gives it 96 pulses. The read clock is synchronised into the system clock domain. The block takes a snapshot of its state on the first falling edge and shifts the snapshot out MSB first. The data changes after each falling edge and is stable when the next rising edge comes. Reading the frame does not clear the peak. The peak is cleared only when both mode bits are zero or when the mute bit is high.

Top module: `pcm_peak_meter`

## Requirements
- R1: While not clearing, a sample strobe replaces the stored peak with max(|left|, |right|) only when that value is strictly greater than the stored peak. The peak never decreases except on a clear.
- R2: The magnitude is the absolute value of a two's-complement sample. The most negative code 0x8000 is saturated to 0x7FFF.
- R3: Shifting out a frame leaves the peak unchanged, so two reads in a row return the same peak.
- R4: While `pk_mode` is 2'b00 or `mute` is 1, the peak reads 0 and any pending time capture is dropped. Sample strobes during that time are ignored.
- R5: After a peak increase, the absolute time of the next subcode strobe with `sq_crc_ok`=1 is latched. Strobes with `sq_crc_ok`=0 are ignored. Later good strobes leave the held absolute time unchanged until the peak increases again.
- R6: Every subcode strobe with `sq_crc_ok`=1 loads its relative time, whether or not a peak is pending.
- R7: Frame layout, bit 95 sent first: bits 95..72 hold the absolute time, bits 71..48 the relative time, bits 47..32 the peak (bit 47 is always 0), bits 31..1 are 0, and bit 0, the left/right flag, is always 0.
- R8: The first falling read-clock edge after idle loads a snapshot, and each later falling edge shifts one bit. A frame is 96 pulses long. Changes to the peak or the times during a read do not alter the frame being sent.
- R9: `ser_out` is 0 while no read is in progress.
- R10: After reset, the peak and both time fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pk_mode | input | 2 | Peak mode control; 2'b00 clears the peak |
| mute | input | 1 | Mute command; 1 clears the peak |
| smp_valid | input | 1 | Sample pair strobe |
| smp_left | input | 16 | Left PCM sample, two's complement |
| smp_right | input | 16 | Right PCM sample, two's complement |
| sq_valid | input | 1 | Subcode frame strobe |
| sq_crc_ok | input | 1 | CRC result of the strobed subcode frame |
| sq_abs_time | input | 24 | Absolute time of the subcode frame |
| sq_rel_time | input | 24 | Relative time of the subcode frame |
| rd_clk | input | 1 | External read clock, idle high |
| ser_out | output | 1 | Serial frame data |

## Verification
The hardest case to reach is a peak increase that arrives while a frame is being shifted out. The snapshot must stay as it was, and the new peak must appear only in the next read. The stimulus forks a 96-pulse read and, about a third of the way through the frame, sends a larger sample. The first frame must then still carry the old peak, and the next read carries the new one. A second hard case is a subcode strobe with a bad CRC that falls between a new peak and the capture. The bench sends such a strobe and expects the absolute time field to keep its old value until a good strobe arrives.

// File: rtl/pcm_peak_meter.sv
module pcm_peak_meter #(
  parameter int W          = 16,
  parameter int TW         = 24,
  parameter int IDLE_LIMIT = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pk_mode,
  input  logic          mute,
  input  logic          smp_valid,
  input  logic [W-1:0]  smp_left,
  input  logic [W-1:0]  smp_right,
  input  logic          sq_valid,
  input  logic          sq_crc_ok,
  input  logic [TW-1:0] sq_abs_time,
  input  logic [TW-1:0] sq_rel_time,
  input  logic          rd_clk,
  output logic          ser_out
);
  localparam int FRAME = 96;
  localparam int PAD   = FRAME - 2*TW - W - 1;
  localparam int CW    = $clog2(FRAME + 1);
  localparam int IW    = $clog2(IDLE_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME);

  function automatic logic [W-1:0] mag(input logic [W-1:0] s);
    if (!s[W-1])                    mag = s;
    else if (s == {1'b1, {(W-1){1'b0}}}) mag = {1'b0, {(W-1){1'b1}}};
    else                            mag = -s;
  endfunction

  // peak tracking
  logic [W-1:0]  peak_q, mag_l, mag_r, mag_max;
  logic [TW-1:0] abs_q, rel_q;
  logic          pend_q, clr, upd, take;

  assign clr     = (pk_mode == 2'b00) || mute;
  assign mag_l   = mag(smp_left);
  assign mag_r   = mag(smp_right);
  assign mag_max = (mag_l > mag_r) ? mag_l : mag_r;
  assign upd     = smp_valid && !clr && (mag_max > peak_q);
  assign take    = sq_valid && sq_crc_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      peak_q <= '0;
      pend_q <= 1'b0;
    end else if (clr) begin
      peak_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (upd) peak_q <= mag_max;
      pend_q <= (pend_q && !take) || upd;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      abs_q <= '0;
      rel_q <= '0;
    end else if (take) begin
      rel_q <= sq_rel_time;
      if (pend_q && !clr) abs_q <= sq_abs_time;
    end

  // read clock sync and serial shifter
  logic [2:0]       rd_s;
  logic             fall_e, rise_e, busy;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    idle_q;
  logic [FRAME-1:0] sh_q, frame;

  assign fall_e = rd_s[2] && !rd_s[1];
  assign rise_e = !rd_s[2] && rd_s[1];
  assign busy   = cnt_q != '0;
  assign frame  = {abs_q, rel_q, peak_q, {PAD{1'b0}}, 1'b0};
  assign ser_out = busy && sh_q[FRAME-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rd_s <= '1;
    else        rd_s <= {rd_s[1:0], rd_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      idle_q <= '0;
    end else begin
      if (busy && rd_s[1] && !rise_e) idle_q <= idle_q + 1'b1;
      else                            idle_q <= '0;
      if (fall_e) begin
        if (!busy) begin
          sh_q  <= frame;
          cnt_q <= CW'(1);
        end else if (cnt_q < LAST) begin
          sh_q  <= sh_q << 1;
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (rise_e && cnt_q == LAST) begin
        cnt_q <= '0;
      end else if (idle_q == IW'(IDLE_LIMIT)) begin
        cnt_q <= '0;
      end
    end

  p_peak_mono_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> peak_q >= $past(peak_q));
  p_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_q[W-1]);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (peak_q == '0) && !pend_q);
  p_abs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pend_q && take) |=> $stable(abs_q));
  p_rel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rel_q));
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fall_e) |=> $stable(sh_q));
  p_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  p_idle_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fall_e) |=> !ser_out);
endmodule

// File: tb/tb_pcm_peak_meter.sv
module tb_pcm_peak_meter;
  localparam int HALF = 6;
  logic clk = 0, rst_n = 0;
  logic [1:0] pk_mode = 2'b01;
  logic mute = 0, smp_valid = 0, sq_valid = 0, sq_crc_ok = 0, rd_clk = 1;
  logic [15:0] smp_left = 0, smp_right = 0;
  logic [23:0] sq_abs_time = 0, sq_rel_time = 0;
  logic ser_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [95:0] exp_q[$];
  logic [15:0] m_peak = 0;
  logic [23:0] m_abs = 0, m_rel = 0;
  bit m_pend = 0;

  always #10 clk = ~clk;

  pcm_peak_meter dut (.clk, .rst_n, .pk_mode, .mute, .smp_valid, .smp_left,
    .smp_right, .sq_valid, .sq_crc_ok, .sq_abs_time, .sq_rel_time, .rd_clk, .ser_out);

  function automatic logic [15:0] fmag(input logic [15:0] s);
    if (s == 16'h8000) return 16'h7fff;
    return s[15] ? -s : s;
  endfunction

  task automatic chk(input string r, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [1:0] m, input logic mu);
    @(negedge clk); pk_mode = m; mute = mu;
    if (m == 2'b00 || mu) begin m_peak = 0; m_pend = 0; end
    @(negedge clk);
  endtask

  task automatic send_sample(input logic [15:0] l, input logic [15:0] r);
    logic [15:0] mx;
    @(negedge clk); smp_left = l; smp_right = r; smp_valid = 1;
    @(negedge clk); smp_valid = 0;
    mx = (fmag(l) > fmag(r)) ? fmag(l) : fmag(r);
    if (!(pk_mode == 2'b00 || mute) && mx > m_peak) begin m_peak = mx; m_pend = 1; end
  endtask

  task automatic send_subq(input logic [23:0] a, input logic [23:0] rl, input logic ok);
    @(negedge clk); sq_abs_time = a; sq_rel_time = rl; sq_crc_ok = ok; sq_valid = 1;
    @(negedge clk); sq_valid = 0;
    if (ok) begin
      m_rel = rl;
      if (m_pend) begin m_abs = a; m_pend = 0; end
    end
  endtask

  task automatic read_frame();
    exp_q.push_back({m_abs, m_rel, m_peak, 31'b0, 1'b0});
    for (int i = 0; i < 96; i++) begin
      @(negedge clk); rd_clk = 0;
      repeat (HALF) @(negedge clk);
      rd_clk = 1;
      repeat (HALF) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // monitor: assemble bits at each rising read edge, compare against queue
  initial begin
    logic [95:0] got, e;
    int n;
    n = 0; got = '0;
    forever begin
      @(posedge rd_clk);
      got = {got[94:0], ser_out};
      n++;
      if (n == 96) begin
        n = 0;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R8 actual=unexpected frame %h expected=none", got);
        end else begin
          e = exp_q.pop_front();
          chk("R5 abs time field", 96'(got[95:72]), 96'(e[95:72]));
          chk("R6 rel time field", 96'(got[71:48]), 96'(e[71:48]));
          chk("R1 peak field", 96'(got[47:32]), 96'(e[47:32]));
          chk("R7 filler and LR flag", 96'(got[31:0]), 96'(e[31:0]));
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 idle ser_out after reset", 96'(ser_out), 96'(0));
    read_frame();                              // R10 zeros after reset
    chk("R9 idle ser_out between reads", 96'(ser_out), 96'(0));

    send_sample(16'd1000, 16'd200);            // R1 left bigger
    send_sample(16'hFC00, 16'd10);             // R2 -1024 magnitude
    send_subq(24'h001234, 24'h000011, 1'b0);   // R5 bad CRC ignored
    read_frame();
    send_subq(24'h001235, 24'h000012, 1'b1);   // R5 capture, R6
    send_sample(16'd500, 16'd900);             // R1 smaller, no change
    send_subq(24'h001236, 24'h000013, 1'b1);   // R5 held, R6 moves
    read_frame();
    read_frame();                              // R3 second read same peak

    send_sample(16'd7, 16'h8000);              // R2 saturation on right
    send_subq(24'h002000, 24'h000020, 1'b1);
    read_frame();

    set_ctl(2'b00, 1'b0);                      // R4 mode clear
    send_sample(16'd3000, 16'd3000);           // ignored while clear
    read_frame();
    set_ctl(2'b10, 1'b0);
    send_sample(16'd3000, 16'hF000);           // R1 right -4096
    send_subq(24'h003000, 24'h000030, 1'b1);
    read_frame();
    set_ctl(2'b10, 1'b1);                      // R4 mute clear
    send_subq(24'h004000, 24'h000040, 1'b1);   // R6 still moves, abs held
    read_frame();
    set_ctl(2'b11, 1'b0);
    send_sample(16'd50, 16'd60);
    fork                                       // R8 snapshot frozen mid-read
      read_frame();
      begin
        repeat (400) @(negedge clk);
        send_sample(16'd20000, 16'd1);
      end
    join
    send_subq(24'h005000, 24'h000050, 1'b1);
    read_frame();
    chk("R9 idle ser_out at end", 96'(ser_out), 96'(0));
    chk("R8 all frames received", 96'(exp_q.size()), 96'(0));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule